// File: doc/BRIEF.md
# Adaptive EPROM Programming Sequencer

This block writes a range of bytes from a buffer into a byte-wide EPROM. For each address it fetches the byte from the buffer and drives address and data to the device. In adaptive mode it then fires short 1 ms program strobes, reading the cell back after each one. As soon as the read-back matches, it fires one over-program strobe four times as long as all the short strobes used so far. It then verifies the byte a final time and moves to the next address. While an adaptive job runs, a supply-select output asks the board for the raised programming supply, and it stays up during every read-back.

A legacy mode serves older small devices. It uses one fixed 50 ms strobe per byte, then a single verify read, and never retries. Millisecond timing comes from a prescaler that is set by a clock-frequency parameter and a scale divisor, so a simulation can run with short pulses. A job covers an inclusive address range given at start. It ends with a one-cycle done pulse, either after the last byte verifies or when a byte fails, in which case a failure flag and the failing address are held until the next start.

Top module: `eprom_pulse_seq`

## Requirements
- R1: After reset, and while idle, rom_we_o, rom_oe_o, supply_hi_o, done_o and fail_o are all 0.
- R2: In adaptive mode each trial strobe lasts exactly one millisecond (MS_CYC clock cycles). Each trial strobe is followed by a read-back. The trial count starts from zero at every address.
- R3: When a trial read-back does not match the buffer byte, another trial strobe follows, up to a limit of MAX_TRIES (default 15) trial strobes per address.
- R4: When a trial read-back matches after N trial strobes, exactly one over-program strobe of OVER_MULT×N ms (default 4×N) is applied to the same address.
- R5: After the over-program strobe the byte is read once more. On a match the sequencer moves to the next address, going upward from start_addr_i to end_addr_i inclusive, so every byte in the range ends up holding its buffer value.
- R6: rom_we_o and rom_oe_o are never high together. Address and data are stable for at least one cycle before rom_we_o rises and stay unchanged while it is high. At least one cycle separates the fall of rom_we_o from the rise of rom_oe_o.
- R7: supply_hi_o is 1 from the first cycle after start until done in adaptive mode, including every read-back. It is 0 throughout a legacy job.
- R8: If the read-back after the MAX_TRIES-th trial strobe still mismatches, the job stops without an over-program strobe. fail_o is then set and fail_addr_o holds the failing address until the next start.
- R9: In legacy mode (legacy_i=1 at start) each byte gets one strobe of LEGACY_MS (default 50) ms and one verify read, with no retry. A mismatch on that read is a failure as in R8.
- R10: done_o is a single-cycle pulse. It comes once per job, after the last address verifies or on a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a job (sampled while idle) |
| legacy_i | input | 1 | 1 selects fixed long-pulse mode for the job |
| start_addr_i | input | ADDR_W | First address of the range |
| end_addr_i | input | ADDR_W | Last address of the range (inclusive) |
| buf_addr_o | output | ADDR_W | Buffer read address |
| buf_data_i | input | DATA_W | Buffer byte at buf_addr_o (same cycle) |
| rom_addr_o | output | ADDR_W | EPROM address |
| rom_data_o | output | DATA_W | Data driven to the EPROM |
| rom_data_i | input | DATA_W | Data read from the EPROM |
| rom_we_o | output | 1 | Program strobe |
| rom_oe_o | output | 1 | Output enable for read-back |
| supply_hi_o | output | 1 | Request raised programming supply |
| done_o | output | 1 | One-cycle job completion pulse |
| fail_o | output | 1 | Job ended on a failing byte |
| fail_addr_o | output | ADDR_W | Address that failed |

## Verification
Two decisions can fall on the same read-back: a match on the trial read and exhaustion of the trial budget. They coincide on the read after the fifteenth trial strobe. The bench provokes this with a device model cell that needs exactly fifteen strobes. It judges the outcome by requiring a 4×15 ms over-program strobe, a clean verify and no failure flag. A cell that needs sixteen strobes must instead fail after fifteen, with no over-program strobe.

// File: rtl/eps_pkg.sv
package eps_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SETUP,
    S_PULSE,
    S_HOLD,
    S_READ,
    S_NEXT,
    S_FAIL
  } eps_state_e;
endpackage

// File: rtl/eps_ms_tick.sv
module eps_ms_tick #(
  parameter int unsigned CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clr_i || !en_i) cnt_q <= '0;
    else if (tick_o)       cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eps_pulse_timer.sv
module eps_pulse_timer #(
  parameter int unsigned CYC  = 1000,
  parameter int unsigned MS_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            busy_o,
  output logic            done_o
);
  logic [MS_W-1:0] left_q;
  logic            tick;

  assign busy_o = (left_q != '0);
  // last tick of the final millisecond
  assign done_o = tick && (left_q == MS_W'(1));

  eps_ms_tick #(.CYC(CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (load_i),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (load_i) left_q <= ms_i;
    else if (tick)   left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/eprom_pulse_seq.sv
module eprom_pulse_seq #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned TICK_SCALE = 1,
  parameter int unsigned MAX_TRIES  = 15,
  parameter int unsigned OVER_MULT  = 4,
  parameter int unsigned LEGACY_MS  = 50
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              legacy_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [DATA_W-1:0] buf_data_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic [DATA_W-1:0] rom_data_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              rom_we_o,
  output logic              rom_oe_o,
  output logic              supply_hi_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fail_addr_o
);
  import eps_pkg::*;

  localparam int unsigned MS_CYC  = (CLK_HZ / 1000 / TICK_SCALE > 0) ? CLK_HZ / 1000 / TICK_SCALE : 1;
  localparam int unsigned OVER_MX = OVER_MULT * MAX_TRIES;
  localparam int unsigned MS_MAX  = (OVER_MX > LEGACY_MS) ? OVER_MX : LEGACY_MS;
  localparam int unsigned MS_W    = $clog2(MS_MAX + 1);
  localparam int unsigned N_W     = $clog2(MAX_TRIES + 1);

  eps_state_e        state_q;
  logic [ADDR_W-1:0] addr_q, end_q, fail_addr_q;
  logic [DATA_W-1:0] data_q;
  logic [N_W-1:0]    n_q;
  logic              final_q, legacy_q, fail_q, done_q;
  logic [MS_W-1:0]   ms_sel;
  logic              tmr_load, tmr_busy, tmr_done, match;

  assign match    = (rom_data_i == data_q);
  assign tmr_load = (state_q == S_SETUP);

  always_comb begin
    if (legacy_q)     ms_sel = MS_W'(LEGACY_MS);
    else if (final_q) ms_sel = MS_W'(OVER_MULT * int'(n_q));
    else              ms_sel = MS_W'(1);
  end

  eps_pulse_timer #(.CYC(MS_CYC), .MS_W(MS_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .ms_i   (ms_sel),
    .busy_o (tmr_busy),
    .done_o (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      addr_q      <= '0;
      end_q       <= '0;
      data_q      <= '0;
      n_q         <= '0;
      final_q     <= 1'b0;
      legacy_q    <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          addr_q   <= start_addr_i;
          end_q    <= end_addr_i;
          legacy_q <= legacy_i;
          final_q  <= legacy_i;   // legacy: one strobe then verify
          n_q      <= '0;
          fail_q   <= 1'b0;
          state_q  <= S_LOAD;
        end
        S_LOAD: begin
          data_q  <= buf_data_i;
          state_q <= S_SETUP;
        end
        S_SETUP: state_q <= S_PULSE;
        S_PULSE: if (tmr_done) begin
          if (!final_q) n_q <= n_q + 1'b1;
          state_q <= S_HOLD;
        end
        S_HOLD: state_q <= S_READ;
        S_READ: begin
          if (final_q)                   state_q <= match ? S_NEXT : S_FAIL;
          else if (match) begin
            final_q <= 1'b1;
            state_q <= S_SETUP;
          end
          else if (n_q == N_W'(MAX_TRIES)) state_q <= S_FAIL;
          else                           state_q <= S_SETUP;
        end
        S_NEXT: begin
          if (addr_q == end_q) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            addr_q  <= addr_q + 1'b1;
            n_q     <= '0;
            final_q <= legacy_q;
            state_q <= S_LOAD;
          end
        end
        S_FAIL: begin
          fail_q      <= 1'b1;
          fail_addr_q <= addr_q;
          done_q      <= 1'b1;
          state_q     <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign buf_addr_o  = addr_q;
  assign rom_addr_o  = addr_q;
  assign rom_data_o  = data_q;
  assign rom_we_o    = (state_q == S_PULSE) && tmr_busy;
  assign rom_oe_o    = (state_q == S_READ);
  assign supply_hi_o = (state_q != S_IDLE) && !legacy_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign fail_addr_o = fail_addr_q;
endmodule

// File: rtl/eps_checker.sv
module eps_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rom_we_o,
  input logic              rom_oe_o,
  input logic              supply_hi_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              legacy_q,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic [DATA_W-1:0] rom_data_o
);
  assert_we_oe_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_we_o && rom_oe_o));

  assert_gap_after_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rom_we_o) |-> !rom_oe_o);

  assert_setup_before_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rom_we_o) |-> ($stable(rom_addr_o) && $stable(rom_data_o)));

  assert_hold_during_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_we_o && $past(rom_we_o)) |-> ($stable(rom_addr_o) && $stable(rom_data_o)));

  assert_supply_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_oe_o && !legacy_q) |-> supply_hi_o);

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fail_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);
endmodule

bind eprom_pulse_seq eps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eps_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rom_we_o    (rom_we_o),
  .rom_oe_o    (rom_oe_o),
  .supply_hi_o (supply_hi_o),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .legacy_q    (legacy_q),
  .rom_addr_o  (rom_addr_o),
  .rom_data_o  (rom_data_o)
);

// File: tb/eprom_pulse_seq_test.sv
module eprom_pulse_seq_test;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MSC = 10;  // 100 kHz / 1000 / 10

  logic          clk_i = 0, rst_ni = 0, start_i = 0, legacy_i = 0;
  logic [AW-1:0] start_addr_i = '0, end_addr_i = '0;
  logic [AW-1:0] buf_addr_o, rom_addr_o, fail_addr_o;
  logic [DW-1:0] buf_data_i, rom_data_o, rom_data_i;
  logic          rom_we_o, rom_oe_o, supply_hi_o, done_o, fail_o;

  int checks = 0, failures = 0;
  int cyc = 0;

  // buffer and device model
  logic [DW-1:0] bufm [256];
  logic [DW-1:0] cellv [256];
  int need [256];
  int pcnt [256];
  int sum_w [256];
  int last_w [256];
  int first_w [256];
  int cur_w = 0;
  logic we_p = 0, done_p = 0;
  int done_cnt = 0, dbl_done = 0, v_overlap = 0, v_gap = 0, v_supply = 0, v_idle = 0;
  bit adaptive_job = 0;

  assign buf_data_i = bufm[buf_addr_o];
  assign rom_data_i = (pcnt[rom_addr_o] >= need[rom_addr_o]) ? cellv[rom_addr_o] : 8'hFF;

  eprom_pulse_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(100_000), .TICK_SCALE(10)) uut (.*);

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) begin
    if (rom_we_o) begin
      if (!we_p) begin
        pcnt[rom_addr_o]++;
        cellv[rom_addr_o] = rom_data_o;
        cur_w = 0;
      end
      cur_w++;
    end else if (we_p) begin
      if (pcnt[rom_addr_o] == 1) first_w[rom_addr_o] = cur_w;
      last_w[rom_addr_o] = cur_w;
      sum_w[rom_addr_o] += cur_w;
    end
    if (rom_we_o && rom_oe_o) v_overlap++;
    if (rom_oe_o && we_p) v_gap++;
    if (adaptive_job && rom_oe_o && !supply_hi_o) v_supply++;
    if (!adaptive_job && supply_hi_o) v_supply++;
    if (done_o) done_cnt++;
    if (done_o && done_p) dbl_done++;
    we_p = rom_we_o;
    done_p = done_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic prep(input int a, input logic [DW-1:0] d, input int n);
    bufm[a] = d; need[a] = n; pcnt[a] = 0; sum_w[a] = 0; last_w[a] = 0; first_w[a] = 0;
    cellv[a] = 8'hFF;
  endtask

  task automatic run_job(input int sa, input int ea, input bit leg);
    @(negedge clk_i);
    done_cnt = 0; dbl_done = 0; v_overlap = 0; v_gap = 0; v_supply = 0;
    adaptive_job = !leg;
    start_addr_i = AW'(sa); end_addr_i = AW'(ea); legacy_i = leg; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    while (!done_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    adaptive_job = 0;
    check(done_cnt == 1 && dbl_done == 0, "R10 done pulse", done_cnt, 1);
    check(v_overlap == 0 && v_gap == 0, "R6 strobe/enable spacing", v_overlap + v_gap, 0);
    check(v_supply == 0, "R7 supply select", v_supply, 0);
  endtask

  task automatic test_reset();
    check(!rom_we_o && !rom_oe_o && !supply_hi_o && !done_o && !fail_o, "R1 reset outputs",
          {rom_we_o, rom_oe_o, supply_hi_o, done_o, fail_o}, 0);
  endtask

  task automatic test_adaptive();
    int nd [4] = '{1, 3, 15, 2};
    for (int i = 0; i < 4; i++) prep(16 + i, DW'(8'h30 + i * 7), nd[i]);
    run_job(16, 19, 0);
    check(!fail_o, "R5 no failure", fail_o, 0);
    for (int i = 0; i < 4; i++) begin
      check(cellv[16 + i] == bufm[16 + i], "R5 byte programmed", cellv[16 + i], bufm[16 + i]);
      check(pcnt[16 + i] == nd[i] + 1, "R3 trial count plus one over-pulse", pcnt[16 + i], nd[i] + 1);
      check(first_w[16 + i] == MSC, "R2 trial width", first_w[16 + i], MSC);
      check(last_w[16 + i] == 4 * nd[i] * MSC, "R4 over-pulse width", last_w[16 + i], 4 * nd[i] * MSC);
      check(sum_w[16 + i] == 5 * nd[i] * MSC, "R2 total strobe time", sum_w[16 + i], 5 * nd[i] * MSC);
    end
    check(pcnt[20] == 0, "R5 stops at end address", pcnt[20], 0);
    check(!supply_hi_o && !rom_we_o, "R1 idle after job", supply_hi_o, 0);
  endtask

  task automatic test_single();
    prep(40, 8'h5A, 4);
    prep(41, 8'h11, 1);
    run_job(40, 40, 0);
    check(pcnt[40] == 5 && last_w[40] == 16 * MSC, "R4 single address", last_w[40], 16 * MSC);
    check(pcnt[41] == 0, "R5 inclusive single range", pcnt[41], 0);
  endtask

  task automatic test_fail();
    prep(50, 8'hA5, 1);
    prep(51, 8'h3C, 16);
    prep(52, 8'h77, 1);
    run_job(50, 52, 0);
    check(fail_o, "R8 fail flag", fail_o, 1);
    check(fail_addr_o == 51, "R8 fail address", fail_addr_o, 51);
    check(pcnt[51] == 15 && sum_w[51] == 15 * MSC, "R8 no over-pulse after limit", pcnt[51], 15);
    check(pcnt[52] == 0, "R8 stops on failure", pcnt[52], 0);
    repeat (20) @(negedge clk_i);
    check(fail_o && fail_addr_o == 51, "R8 fail held", fail_addr_o, 51);
  endtask

  task automatic test_legacy();
    prep(60, 8'h12, 1);
    prep(61, 8'h34, 1);
    run_job(60, 61, 1);
    check(!fail_o, "R9 legacy clears fail", fail_o, 0);
    for (int i = 60; i < 62; i++) begin
      check(pcnt[i] == 1, "R9 single legacy strobe", pcnt[i], 1);
      check(last_w[i] == 50 * MSC, "R9 legacy width", last_w[i], 50 * MSC);
      check(cellv[i] == bufm[i], "R9 legacy data", cellv[i], bufm[i]);
    end
    prep(70, 8'h99, 2);
    prep(71, 8'h98, 1);
    run_job(70, 71, 1);
    check(fail_o && fail_addr_o == 70, "R9 legacy verify failure", fail_addr_o, 70);
    check(pcnt[70] == 1 && pcnt[71] == 0, "R9 no legacy retry", pcnt[70], 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) prep(i, 8'h00, 1);
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    test_reset();
    test_adaptive();
    test_single();
    test_fail();
    test_legacy();
    finish_run();
  end
endmodule